// File: doc/BRIEF.md
# Shared Product-Term Sum Array

This block is the sum-of-products core of one programmable logic block. A 44-bit input vector, some of whose positions may be swapped for feedback from the block's own outputs, is expanded into true and inverted literals. Eighty-two configurable product terms are formed from those literals. Eighty of them are grouped four to a group, one group per output. Each group's OR can be steered into its own output or into a neighbouring output up to three positions away. This lets one output collect as many as seven groups, or 28 terms. An output can also take a short bypass path that uses only its own four terms. The last two terms are brought out on their own as a shared clock term and an I/O control term.

Configuration lives in registers loaded through a 32-bit address/data write port. The sums and the spare terms are purely combinational from the inputs and the stored configuration. A configuration write becomes visible right after the clock edge on which it is accepted.

Top module: `ptsa_array`

## Requirements
- R1: Product term t is configured by an 88-bit select vector. Bit k (k < 44) picks the true form of effective input k, and bit 44+k picks its inverse. The term is the AND of the picked literals and is 0 when no literal is picked.
- R2: When bit i (i < 20) of the feedback-select word is set, effective input i is `fb_vec[i]` instead of `in_vec[i]`. Positions 20 to 43 always come from `in_vec`.
- R3: Reset clears all configuration, so every sum and both spare outputs are 0 for any input.
- R4: Group g (terms 4g..4g+3) sends its OR to output g+d. Here d is the signed 3-bit value in bits [2:0] of the group's control word, and reset gives d = 0. Code 3'b100, or a destination outside 0..19, sends the group nowhere.
- R5: An output not in bypass is the OR of every group aimed at it, so it can combine seven groups (28 terms).
- R6: When bit 3 of group g's control word is set, output g is the OR of terms 4g..4g+3 alone, and every group aimed at output g is ignored.
- R7: A group aimed at another output adds nothing to its own output, unless that output is in bypass.
- R8: Term 80 drives `spare_clk_pt` and term 81 drives `spare_ioctl_pt`. Neither enters any sum.
- R9: The write address map is as follows. Term t word j (j = 0..2) sits at address 3t+j and holds select bits 32j..32j+31; bits above 87 are dropped. Group g control is at 256+g. The feedback select is at 276, in its bits [19:0]. Writes to any other address change nothing, and a write counts only on a clock edge with `cfg_we` high.
- R10: Between writes, sums and spare outputs follow the inputs combinationally, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Asynchronous active-low reset, clears configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 9 | Configuration word address |
| cfg_wdata | input | 32 | Configuration word data |
| in_vec | input | 44 | Primary input vector |
| fb_vec | input | 20 | Feedback from the block's own outputs |
| sum_out | output | 20 | Per-output sums |
| spare_clk_pt | output | 1 | Spare term used as a shared clock source |
| spare_ioctl_pt | output | 1 | Spare term driving an I/O control line |

## Verification
The assertions watch three things on every cycle. A bypassed output always equals its own group's OR. A set sum that is not bypassed always has at least one active group aimed at it. The outputs never move while the inputs hold and no write occurred. The assertions also check that group and feedback-select writes land in the addressed register on the next cycle. Only the bench scenarios can show the rest: how literals are chosen, where the feedback substitution falls, that a 28-term merge spans exactly the window edges, that out-of-range and disabled destinations vanish, and that unmapped or high-bit writes have no effect.

// File: rtl/ptsa_pkg.sv
package ptsa_pkg;
   localparam int WORD_W = 32;

   function automatic int ceil_div(input int a, input int b);
      return (a + b - 1) / b;
   endfunction

   function automatic int pow2_ceil(input int a);
      int p;
      p = 1;
      while (p < a) p = p * 2;
      return p;
   endfunction
endpackage

// File: rtl/ptsa_term.sv
module ptsa_term #(
   parameter int LIT_W = 88
) (
   input  logic [LIT_W-1:0] lits,
   input  logic [LIT_W-1:0] pick,
   output logic             hit
);
   // unpicked literals are forced high; an empty pick forces the term low
   assign hit = (|pick) & (&(lits | ~pick));
endmodule

// File: rtl/ptsa_cfg_regs.sv
module ptsa_cfg_regs
   import ptsa_pkg::*;
#(
   parameter int N_PT    = 82,
   parameter int LIT_W   = 88,
   parameter int N_OUT   = 20,
   parameter int OFS_W   = 3,
   parameter int N_FB    = 20,
   parameter int ADDR_W  = 9,
   parameter int WPT     = 3,
   parameter int GRP_BASE = 256,
   parameter int FB_BASE  = 276
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [WORD_W-1:0]             wdata,
   output logic [N_PT-1:0][LIT_W-1:0]    term_pick,
   output logic [N_OUT-1:0][OFS_W-1:0]   grp_ofs,
   output logic [N_OUT-1:0]              grp_byp,
   output logic [N_FB-1:0]               fb_sel
);
   localparam int TI_W = $clog2(N_PT);

   logic [ADDR_W-1:0] term_q;
   logic [ADDR_W-1:0] word_q;

   assign term_q = addr / ADDR_W'(WPT);
   assign word_q = addr % ADDR_W'(WPT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         term_pick <= '0;
         grp_ofs   <= '0;
         grp_byp   <= '0;
         fb_sel    <= '0;
      end else if (we) begin
         if (term_q < ADDR_W'(N_PT)) begin
            for (int b = 0; b < LIT_W; b++) begin
               if (int'(word_q) == b / WORD_W)
                  term_pick[term_q[TI_W-1:0]][b] <= wdata[b % WORD_W];
            end
         end
         for (int g = 0; g < N_OUT; g++) begin
            if (addr == ADDR_W'(GRP_BASE + g)) begin
               grp_ofs[g] <= wdata[OFS_W-1:0];
               grp_byp[g] <= wdata[OFS_W];
            end
         end
         if (addr == ADDR_W'(FB_BASE))
            fb_sel <= wdata[N_FB-1:0];
      end
   end
endmodule

// File: rtl/ptsa_share.sv
module ptsa_share #(
   parameter int N_OUT  = 20,
   parameter int GRP_SZ = 4,
   parameter int REACH  = 3,
   parameter int OFS_W  = 3
) (
   input  logic [N_OUT*GRP_SZ-1:0]      terms,
   input  logic [N_OUT-1:0][OFS_W-1:0]  grp_ofs,
   input  logic [N_OUT-1:0]             grp_byp,
   output logic [N_OUT-1:0]             sums
);
   logic [N_OUT-1:0] grp_or;

   for (genvar g = 0; g < N_OUT; g++) begin : g_grp
      assign grp_or[g] = |terms[g*GRP_SZ +: GRP_SZ];
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_out
      logic shared;
      always_comb begin
         shared = 1'b0;
         for (int d = -REACH; d <= REACH; d++) begin
            if ((o - d) >= 0 && (o - d) < N_OUT) begin
               if (grp_ofs[o - d] == OFS_W'(d))
                  shared = shared | grp_or[o - d];
            end
         end
      end
      assign sums[o] = grp_byp[o] ? grp_or[o] : shared;
   end
endmodule

// File: rtl/ptsa_array.sv
module ptsa_array
   import ptsa_pkg::*;
#(
   parameter int N_IN    = 44,
   parameter int N_OUT   = 20,
   parameter int GRP_SZ  = 4,
   parameter int N_SPARE = 2,
   parameter int REACH   = 3,
   parameter int N_FB    = 20,
   parameter int ADDR_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [ADDR_W-1:0] cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic [N_IN-1:0]   in_vec,
   input  logic [N_FB-1:0]   fb_vec,
   output logic [N_OUT-1:0]  sum_out,
   output logic              spare_clk_pt,
   output logic              spare_ioctl_pt
);
   localparam int N_GEN      = N_OUT * GRP_SZ;
   localparam int N_PT       = N_GEN + N_SPARE;
   localparam int LIT_W      = 2 * N_IN;
   localparam int WPT        = ceil_div(LIT_W, WORD_W);
   localparam int TERM_WORDS = N_PT * WPT;
   localparam int GRP_BASE   = pow2_ceil(TERM_WORDS);
   localparam int FB_BASE    = GRP_BASE + N_OUT;
   localparam int OFS_W      = $clog2(REACH + 1) + 1;

   if (N_FB > N_IN || N_FB > WORD_W) begin : g_bad_fb
      $error("feedback width must not exceed input or word width");
   end
   if (N_SPARE != 2) begin : g_bad_spare
      $error("exactly two spare terms are brought out");
   end
   if (OFS_W + 1 > WORD_W) begin : g_bad_ofs
      $error("group control field does not fit a word");
   end
   if ((1 << ADDR_W) <= FB_BASE) begin : g_bad_addr
      $error("address width too small for the map");
   end

   logic [N_PT-1:0][LIT_W-1:0]  term_pick;
   logic [N_OUT-1:0][OFS_W-1:0] grp_ofs;
   logic [N_OUT-1:0]            grp_byp;
   logic [N_FB-1:0]             fb_sel;
   logic [N_IN-1:0]             eff_in;
   logic [LIT_W-1:0]            lits;
   logic [N_PT-1:0]             term_val;

   ptsa_cfg_regs #(
      .N_PT(N_PT), .LIT_W(LIT_W), .N_OUT(N_OUT), .OFS_W(OFS_W), .N_FB(N_FB),
      .ADDR_W(ADDR_W), .WPT(WPT), .GRP_BASE(GRP_BASE), .FB_BASE(FB_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
      .term_pick(term_pick), .grp_ofs(grp_ofs), .grp_byp(grp_byp), .fb_sel(fb_sel)
   );

   for (genvar i = 0; i < N_IN; i++) begin : g_in
      if (i < N_FB) begin : g_fb
         assign eff_in[i] = fb_sel[i] ? fb_vec[i] : in_vec[i];
      end else begin : g_plain
         assign eff_in[i] = in_vec[i];
      end
   end

   assign lits = {~eff_in, eff_in};

   for (genvar t = 0; t < N_PT; t++) begin : g_term
      ptsa_term #(.LIT_W(LIT_W)) u_term (
         .lits(lits), .pick(term_pick[t]), .hit(term_val[t])
      );
   end

   ptsa_share #(
      .N_OUT(N_OUT), .GRP_SZ(GRP_SZ), .REACH(REACH), .OFS_W(OFS_W)
   ) u_share (
      .terms(term_val[N_GEN-1:0]), .grp_ofs(grp_ofs), .grp_byp(grp_byp),
      .sums(sum_out)
   );

   assign spare_clk_pt   = term_val[N_GEN];
   assign spare_ioctl_pt = term_val[N_GEN + 1];
endmodule

// File: rtl/ptsa_array_chk.sv
module ptsa_array_chk #(
   parameter int N_IN     = 44,
   parameter int N_OUT    = 20,
   parameter int GRP_SZ   = 4,
   parameter int N_PT     = 82,
   parameter int REACH    = 3,
   parameter int OFS_W    = 3,
   parameter int N_FB     = 20,
   parameter int ADDR_W   = 9,
   parameter int GRP_BASE = 256,
   parameter int FB_BASE  = 276
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_we,
   input logic [ADDR_W-1:0]            cfg_addr,
   input logic [N_FB-1:0]              wd_fb,
   input logic [OFS_W:0]               wd_grp,
   input logic [N_IN-1:0]              in_vec,
   input logic [N_FB-1:0]              fb_vec,
   input logic [N_OUT-1:0]             sum_out,
   input logic [N_PT-1:0]              term_val,
   input logic [N_OUT-1:0][OFS_W-1:0]  grp_ofs,
   input logic [N_OUT-1:0]             grp_byp,
   input logic [N_FB-1:0]              fb_sel
);
   logic [N_OUT-1:0] has_src;

   always_comb begin
      for (int o = 0; o < N_OUT; o++) begin
         has_src[o] = 1'b0;
         for (int d = -REACH; d <= REACH; d++) begin
            if ((o - d) >= 0 && (o - d) < N_OUT) begin
               if (grp_ofs[o - d] == OFS_W'(d) && (|term_val[(o - d)*GRP_SZ +: GRP_SZ]))
                  has_src[o] = 1'b1;
            end
         end
      end
   end

   for (genvar o = 0; o < N_OUT; o++) begin : g_chk
      // R6: a bypassed output mirrors its own four terms
      a_r6_bypass_own: assert property (@(posedge clk) disable iff (!rst_n)
         grp_byp[o] |-> (sum_out[o] == (|term_val[o*GRP_SZ +: GRP_SZ])));

      // R7: a set shared sum needs an active group aimed at it
      a_r7_needs_source: assert property (@(posedge clk) disable iff (!rst_n)
         (!grp_byp[o] && sum_out[o]) |-> has_src[o]);

      // R9: group control write lands on the next cycle
      a_r9_grp_write: assert property (@(posedge clk) disable iff (!rst_n)
         (cfg_we && cfg_addr == ADDR_W'(GRP_BASE + o)) |=>
            (grp_ofs[o] == $past(wd_grp[OFS_W-1:0]) && grp_byp[o] == $past(wd_grp[OFS_W])));
   end

   // R9: feedback select write lands on the next cycle
   a_r9_fb_write: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == ADDR_W'(FB_BASE)) |=> (fb_sel == $past(wd_fb)));

   // R10: no write and steady inputs keep the sums steady
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(cfg_we) && $stable(in_vec) && $stable(fb_vec)) |-> $stable(sum_out));
endmodule

bind ptsa_array ptsa_array_chk #(
   .N_IN(N_IN), .N_OUT(N_OUT), .GRP_SZ(GRP_SZ), .N_PT(N_PT), .REACH(REACH),
   .OFS_W(OFS_W), .N_FB(N_FB), .ADDR_W(ADDR_W), .GRP_BASE(GRP_BASE), .FB_BASE(FB_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .wd_fb(cfg_wdata[N_FB-1:0]), .wd_grp(cfg_wdata[OFS_W:0]),
   .in_vec(in_vec), .fb_vec(fb_vec), .sum_out(sum_out), .term_val(term_val),
   .grp_ofs(grp_ofs), .grp_byp(grp_byp), .fb_sel(fb_sel)
);

// File: tb/ptsa_array_test.sv
module ptsa_array_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [8:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [43:0] in_vec = '0;
   logic [19:0] fb_vec = '0;
   logic [19:0] sum_out;
   logic        spare_clk_pt, spare_ioctl_pt;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   bit [87:0] m_pick [82];
   bit [2:0]  m_ofs [20];
   bit        m_byp [20];
   bit [19:0] m_fb;

   always #5 clk = ~clk;

   ptsa_array uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .in_vec(in_vec), .fb_vec(fb_vec),
      .sum_out(sum_out), .spare_clk_pt(spare_clk_pt), .spare_ioctl_pt(spare_ioctl_pt)
   );

   function automatic bit [21:0] model();
      bit [43:0] e;
      bit [87:0] l;
      bit [81:0] tv;
      bit [19:0] gor, acc, s;
      for (int i = 0; i < 44; i++) e[i] = (i < 20 && m_fb[i]) ? fb_vec[i] : in_vec[i];
      l = {~e, e};
      for (int t = 0; t < 82; t++) tv[t] = (m_pick[t] != 0) && ((l & m_pick[t]) == m_pick[t]);
      acc = '0;
      for (int g = 0; g < 20; g++) begin
         int d, dst;
         gor[g] = |tv[g*4 +: 4];
         d = int'($signed(m_ofs[g]));
         dst = g + d;
         if (d >= -3 && d <= 3 && dst >= 0 && dst < 20) acc[dst] = acc[dst] | gor[g];
      end
      for (int o = 0; o < 20; o++) s[o] = m_byp[o] ? gor[o] : acc[o];
      return {tv[81], tv[80], s};
   endfunction

   task automatic chk(input string req, input bit [21:0] exp);
      bit [21:0] act;
      #1;
      act = {spare_ioctl_pt, spare_clk_pt, sum_out};
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_model(input string req);
      chk(req, model());
   endtask

   task automatic wr(input int a, input bit [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 9'(a); cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (a < 246) begin
         for (int b = 0; b < 88; b++) if (b / 32 == a % 3) m_pick[a / 3][b] = d[b % 32];
      end else if (a >= 256 && a < 276) begin
         m_ofs[a - 256] = d[2:0];
         m_byp[a - 256] = d[3];
      end else if (a == 276) begin
         m_fb = d[19:0];
      end
   endtask

   task automatic set_term(input int t, input bit [87:0] v);
      wr(3*t, v[31:0]); wr(3*t + 1, v[63:32]); wr(3*t + 2, {8'h00, v[87:64]});
   endtask

   function automatic bit [87:0] lit1(input int k);
      bit [87:0] v = '0;
      v[k] = 1'b1;
      return v;
   endfunction

   task automatic clear_all();
      for (int t = 0; t < 82; t++) set_term(t, '0);
      for (int g = 0; g < 20; g++) wr(256 + g, 0);
      wr(276, 0);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1357));
      for (int t = 0; t < 82; t++) m_pick[t] = '0;
      for (int g = 0; g < 20; g++) begin m_ofs[g] = '0; m_byp[g] = 1'b0; end
      m_fb = '0;
      in_vec = {$urandom(), $urandom()};
      fb_vec = 20'($urandom());
      // R3: config cleared in reset, outputs zero for any input
      repeat (2) @(negedge clk);
      chk("R3 reset", 22'h0);
      rst_n = 1'b1;
      @(negedge clk);
      in_vec = '1; fb_vec = '1;
      chk("R3 after reset all ones", 22'h0);

      // R1: term 0 = in[0] & ~in[1]
      set_term(0, lit1(0) | lit1(44 + 1));
      @(negedge clk); in_vec = '0; in_vec[0] = 1'b1;
      chk("R1 literal and true", 22'h1);
      @(negedge clk); in_vec[1] = 1'b1;
      chk("R1 literal and false", 22'h0);
      // R10: same-cycle follow of inputs
      @(negedge clk); in_vec[1] = 1'b0;
      chk("R10 combinational follow", 22'h1);

      // R2: term 4 = in[5]; feedback replaces position 5
      set_term(4, lit1(5));
      @(negedge clk); in_vec[5] = 1'b0; fb_vec = '0; fb_vec[5] = 1'b1;
      chk("R2 no feedback select", 22'h1);
      wr(276, 32'h0000_0020);
      chk("R2 feedback selected", 22'h3);
      // R2: position 43 term never switched
      set_term(8, lit1(43));
      @(negedge clk); in_vec[43] = 1'b1;
      chk_model("R2 high position direct");
      clear_all();
      @(negedge clk); in_vec = '0; fb_vec = '0;

      // R5: groups 7..13 aimed at output 10, each group's term on its own input
      for (int g = 7; g <= 13; g++) begin
         set_term(4*g + (g % 4), lit1(g));
         wr(256 + g, 32'(10 - g) & 32'h7);
      end
      for (int g = 7; g <= 13; g++) begin
         @(negedge clk); in_vec = '0; in_vec[g] = 1'b1;
         chk($sformatf("R5 wide sum group %0d", g), 22'(1 << 10));
      end
      // R7: group 12 given to output 10, its own output stays low
      @(negedge clk); in_vec = '0; in_vec[12] = 1'b1;
      chk("R7 donated group", 22'(1 << 10));
      // R6: bypass on output 10 keeps only group 10
      wr(266, 32'h8);
      chk("R6 bypass ignores neighbours", 22'h0);
      @(negedge clk); in_vec = '0; in_vec[10] = 1'b1;
      chk("R6 bypass own group", 22'(1 << 10));
      // R7 with bypass: group 12 own output in bypass sees its terms
      wr(268, 32'h8 | 32'h6);
      @(negedge clk); in_vec = '0; in_vec[12] = 1'b1;
      chk("R7 bypass on donor output", 22'(1 << 12));
      clear_all();

      // R4: off-edge destination and disabled code
      set_term(4, lit1(2));
      wr(257, 32'h5);
      @(negedge clk); in_vec = '0; in_vec[2] = 1'b1;
      chk("R4 destination below zero", 22'h0);
      wr(257, 32'h4);
      chk("R4 disabled code", 22'h0);
      wr(257, 32'h1);
      chk("R4 shift up one", 22'h4);

      // R8: spare terms
      set_term(80, lit1(3));
      set_term(81, lit1(44 + 3));
      @(negedge clk); in_vec[3] = 1'b1;
      chk("R8 spare clock term", 22'h4 | 22'(1 << 20));
      @(negedge clk); in_vec[3] = 1'b0;
      chk("R8 spare control term", 22'h4 | 22'(1 << 21));

      // R9: unmapped and dropped-bit writes have no effect
      wr(250, 32'hFFFF_FFFF);
      wr(277, 32'hFFFF_FFFF);
      wr(14, 32'hFF00_0000);
      @(negedge clk); in_vec = '1;
      chk("R9 unmapped writes ignored", 22'h4 | 22'(1 << 20));
      @(negedge clk); cfg_we = 1'b0; cfg_addr = 9'd3; cfg_wdata = 32'hFFFF_FFFF;
      @(negedge clk);
      chk_model("R9 write needs strobe");

      // R10 with R1..R6 mixed: random configuration and inputs
      for (int n = 0; n < 400; n++) begin
         int k = $urandom_range(0, 9);
         if (k < 4) begin
            bit [87:0] v = '0;
            int c = $urandom_range(1, 3);
            for (int q = 0; q < c; q++) v[$urandom_range(0, 87)] = 1'b1;
            set_term($urandom_range(0, 81), v);
         end else if (k < 6) begin
            wr(256 + $urandom_range(0, 19),
               32'($urandom_range(0, 7)) | (($urandom_range(0, 7) == 0) ? 32'h8 : 32'h0));
         end else if (k == 6) begin
            wr(276, $urandom());
         end else begin
            @(negedge clk);
            in_vec = {$urandom(), $urandom()};
            fb_vec = 20'($urandom());
         end
         chk_model("R10 random mix");
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule